// File: doc/BRIEF.md
# Wake Reason Recorder

This block keeps a sticky record of the events that brought the device out of, or kept it from entering, a low power state. The record holds one bit for each peripheral wake source, one bit for a fall-through event (an interrupt released the core from its wait-for-interrupt while entry was under way, so entry was halted), and one bit for an abort event (a flash, life-cycle or OTP transaction was still running when entry was attempted, so entry was halted). The fall-through and abort conditions are detected elsewhere and reach this block as single-cycle pulses. The wake vector arrives already masked by the wake enables.

Recording is armed by the pulse that marks the start of a valid low-power entry. Once armed, every cycle ORs the incoming reasons into the record, and it keeps doing so after the device returns to the active state, so several reasons can pile up. Software stops recording by setting a disable control bit. That bit also disarms the recorder, and only the next low-power entry arms it again. Software reads the record and clears individual bits by writing ones.

Top module: `wake_cause_rec`

## Requirements
- R1: After reset the record reads 0 and the recorder is disarmed.
- R2: While disarmed, wake, fall-through and abort inputs leave the record unchanged.
- R3: An entry pulse with the disable bit at 0 arms the recorder. Reasons present in that same cycle are recorded, and so are reasons in every later cycle while it stays armed. The record output shows each cycle's result one clock later.
- R4: The record layout is: wake source k at bit k (bits NUM_WAKE-1:0), fall-through at bit NUM_WAKE, and abort at bit NUM_WAKE+1. With the default NUM_WAKE=6 these are bits 5:0, bit 6 and bit 7.
- R5: Recorded bits are sticky. A bit stays set after its input drops, and new reasons are ORed on top of the bits already set.
- R6: While the disable bit is 1, nothing is recorded and the recorder disarms. If the disable bit then returns to 0 with no new entry pulse, reasons are still not recorded.
- R7: After a disable, the next entry pulse arms the recorder again.
- R8: A clear strobe with a data word clears every record bit at whose position the data holds 1, and leaves the other bits unchanged.
- R9: When a clear and a capture hit the same bit in the same cycle, the bit ends up set.
- R10: An entry pulse that arrives while the disable bit is 1 does not arm the recorder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| lp_entry_i | input | 1 | Single-cycle pulse at the start of a valid low-power entry |
| wake_req_i | input | NUM_WAKE | Masked peripheral wake requests |
| fall_thru_i | input | 1 | Fall-through event pulse |
| abort_i | input | 1 | Abort event pulse |
| cap_dis_i | input | 1 | Capture disable control (1 = suppress and disarm) |
| clr_we_i | input | 1 | Write strobe for write-1-to-clear |
| clr_data_i | input | NUM_WAKE+2 | Clear mask; a 1 clears that record bit |
| rec_o | output | NUM_WAKE+2 | Recorded wake reasons |

## Verification
The bench builds the recorder with the default NUM_WAKE=6, so the record is 8 bits wide and the fall-through and abort bits land at bits 6 and 7. This puts every layout position within reach of a short directed sequence. The sequence passes through every arming transition: reasons applied before the first entry, arming with a reason in the entry cycle, disabling, an entry pulse while disabled, and re-arming. It also drives a clear and a capture onto the same bit in one cycle.

// File: rtl/wcr_pkg.sv
package wcr_pkg;

  // Arming state of the recorder
  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_LIVE  = 1'b1
  } arm_state_e;

  localparam int unsigned DEF_NUM_WAKE = 6;

endpackage

// File: rtl/wcr_arm_ctrl.sv
module wcr_arm_ctrl
  import wcr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_entry_i,
  input  logic cap_dis_i,
  output logic cap_en_o
);

  arm_state_e state_q, state_d;
  logic       state_we;

  always_comb begin
    state_d = state_q;
    if (cap_dis_i) begin
      state_d = ARM_IDLE;
    end else if (lp_entry_i) begin
      state_d = ARM_LIVE;
    end
  end

  assign state_we = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARM_IDLE;
    end else if (state_we) begin
      state_q <= state_d;
    end
  end

  // Capture runs in the entry cycle too, unless disabled
  assign cap_en_o = ((state_q == ARM_LIVE) || lp_entry_i) && !cap_dis_i;

  AST_DISARM_ON_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_dis_i |=> (state_q == ARM_IDLE)); // R6

  AST_ARM_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_entry_i && !cap_dis_i) |=> (state_q == ARM_LIVE)); // R7

  AST_NO_ARM_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_entry_i && cap_dis_i) |=> (state_q == ARM_IDLE)); // R10

endmodule

// File: rtl/wcr_rec_reg.sv
module wcr_rec_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [WIDTH-1:0] sample_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] rec_o
);

  logic [WIDTH-1:0] rec_q;
  logic [WIDTH-1:0] rec_d;
  logic [WIDTH-1:0] bit_we;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic clr_hit;
    logic set_hit;

    always_comb begin
      clr_hit   = clr_we_i && clr_data_i[i];
      set_hit   = cap_en_i && sample_i[i];
      bit_we[i] = clr_hit || set_hit;
      // a set in the same cycle wins over a clear
      rec_d[i]  = set_hit || (rec_q[i] && !clr_hit);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rec_q[i] <= 1'b0;
      end else if (bit_we[i]) begin
        rec_q[i] <= rec_d[i];
      end
    end
  end

  assign rec_o = rec_q;

  AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((rec_q & $past(rec_q)) == $past(rec_q))); // R5

  AST_CAPTURE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !clr_we_i) |=> ((rec_q & $past(sample_i)) == $past(sample_i))); // R3

  AST_CLEAR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !cap_en_i) |=> ((rec_q & $past(clr_data_i)) == '0)); // R8

  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && cap_en_i) |=> ((rec_q & $past(sample_i)) == $past(sample_i))); // R9

endmodule

// File: rtl/wake_cause_rec.sv
module wake_cause_rec
  import wcr_pkg::*;
#(
  parameter int unsigned NUM_WAKE = DEF_NUM_WAKE,
  localparam int unsigned REC_W   = NUM_WAKE + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lp_entry_i,
  input  logic [NUM_WAKE-1:0] wake_req_i,
  input  logic                fall_thru_i,
  input  logic                abort_i,
  input  logic                cap_dis_i,
  input  logic                clr_we_i,
  input  logic [REC_W-1:0]    clr_data_i,
  output logic [REC_W-1:0]    rec_o
);

  localparam int unsigned FT_POS = NUM_WAKE;
  localparam int unsigned AB_POS = NUM_WAKE + 1;

  logic             cap_en;
  logic [REC_W-1:0] sample;

  always_comb begin
    sample                 = '0;
    sample[NUM_WAKE-1:0]   = wake_req_i;
    sample[FT_POS]         = fall_thru_i;
    sample[AB_POS]         = abort_i;
  end

  wcr_arm_ctrl u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lp_entry_i (lp_entry_i),
    .cap_dis_i  (cap_dis_i),
    .cap_en_o   (cap_en)
  );

  wcr_rec_reg #(
    .WIDTH (REC_W)
  ) u_rec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en),
    .sample_i   (sample),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .rec_o      (rec_o)
  );

  AST_DIS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_dis_i && !clr_we_i) |=> $stable(rec_o)); // R6

  AST_FT_POSITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en && fall_thru_i) |=> rec_o[FT_POS]); // R4

  AST_AB_POSITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en && abort_i) |=> rec_o[AB_POS]); // R4

endmodule

// File: tb/wake_cause_rec_bench.sv
module wake_cause_rec_bench;

  localparam int unsigned PERIOD   = 10;
  localparam int unsigned NUM_WAKE = 6;
  localparam int unsigned REC_W    = NUM_WAKE + 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                lp_entry = 1'b0;
  logic [NUM_WAKE-1:0] wake = '0;
  logic                ft = 1'b0;
  logic                ab = 1'b0;
  logic                dis = 1'b0;
  logic                clr_we = 1'b0;
  logic [REC_W-1:0]    clr_data = '0;
  logic [REC_W-1:0]    rec;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;

  typedef struct {
    logic [REC_W-1:0] exp;
    string            tag;
  } item_t;

  item_t q[$];

  // bench-side model state
  logic             m_armed = 1'b0;
  logic [REC_W-1:0] m_rec   = '0;

  always #(PERIOD/2) clk = ~clk;

  wake_cause_rec #(.NUM_WAKE(NUM_WAKE)) u_wake_cause_rec (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .lp_entry_i (lp_entry),
    .wake_req_i (wake),
    .fall_thru_i(ft),
    .abort_i    (ab),
    .cap_dis_i  (dis),
    .clr_we_i   (clr_we),
    .clr_data_i (clr_data),
    .rec_o      (rec)
  );

  task automatic check(input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp,
                       input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rec actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected record
  task automatic step(input logic e, input logic [NUM_WAKE-1:0] w, input logic f,
                      input logic a, input logic d, input logic cw,
                      input logic [REC_W-1:0] cd, input string tag);
    logic             cap;
    logic [REC_W-1:0] smp;
    @(negedge clk);
    lp_entry = e; wake = w; ft = f; ab = a; dis = d; clr_we = cw; clr_data = cd;
    cap = (m_armed || e) && !d;
    smp = {a, f, w};
    if (cw) m_rec = m_rec & ~cd;
    if (cap) m_rec = m_rec | smp;
    if (d) m_armed = 1'b0;
    else if (e) m_armed = 1'b1;
    q.push_back('{exp: m_rec, tag: tag});
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/5);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(rec, it.exp, it.tag);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/5);
    check(rec, '0, "R1 reset value");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(PERIOD/5);
    check(rec, '0, "R1 after release");

    step(0, 6'h3F, 1, 1, 0, 0, 8'h00, "R2 disarmed all reasons");
    step(0, 6'h05, 0, 1, 0, 0, 8'h00, "R2 disarmed again");
    step(1, 6'h01, 0, 0, 0, 0, 8'h00, "R3 capture in entry cycle");
    step(0, 6'h04, 0, 0, 0, 0, 8'h00, "R5 accumulate");
    step(0, 6'h00, 0, 0, 0, 0, 8'h00, "R5 sticky after drop");
    step(0, 6'h00, 1, 0, 0, 0, 8'h00, "R4 fall-through at bit 6");
    step(0, 6'h00, 0, 1, 0, 0, 8'h00, "R4 abort at bit 7");
    step(0, 6'h00, 0, 0, 0, 1, 8'h41, "R8 clear selected bits");
    step(0, 6'h04, 0, 0, 0, 1, 8'h04, "R9 set beats clear");
    step(0, 6'h3F, 1, 1, 1, 0, 8'h00, "R6 disabled no capture");
    step(0, 6'h3F, 1, 0, 0, 0, 8'h00, "R6 stays disarmed");
    step(1, 6'h02, 0, 0, 1, 0, 8'h00, "R10 entry while disabled");
    step(0, 6'h02, 0, 0, 0, 0, 8'h00, "R10 not armed after");
    step(1, 6'h00, 0, 0, 0, 0, 8'h00, "R7 re-arm");
    step(0, 6'h10, 0, 0, 0, 0, 8'h00, "R7 capture after re-arm");
    step(0, 6'h00, 0, 0, 0, 1, 8'hFF, "R8 clear all");
    step(0, 6'h00, 0, 0, 0, 0, 8'h00, "R8 idle after clear");

    repeat (3) @(posedge clk);
    #(PERIOD/5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule